// File: doc/BRIEF.md
# Store Gathering Write Combiner

This block sits between the store queue of a load/store unit and a 64-bit system bus. It reads the two oldest queue entries and issues the head entry as one bus write. The bus write carries a doubleword-aligned address, 64 bits of lane-placed data and 8 byte enables. Two 4-byte stores are merged into a single-beat write with all byte enables set when all of these hold:

- both stores are word-aligned;
- both target non-guarded memory that is write-through or cache-inhibited;
- both carry no excluding flags;
- both fall in the two different word halves of one doubleword.

The stores may arrive lower word first or upper word first.

Gathering is controlled by a global enable input and is allowed only in big-endian mode. The decision is made when the head entry is captured, so only stores that are pending together are merged. A lone store never waits for a partner. The captured request stays unchanged until the bus accepts it. When the bus accepts it, the block pops the head entry, and also the second entry if the two were merged.

Top module: `sg_write_combiner`

## Requirements
- R1: A store can merge only if its attribute field (bit 2 guarded, bit 1 cache-inhibited, bit 0 write-through) shows non-guarded memory with write-through or cache-inhibited set. Any other store goes out alone.
- R2: A store can merge only if its size code is 2 (4 bytes; codes 0, 1, 2, 3 mean 1, 2, 4, 8 bytes) and its address bits [1:0] are zero.
- R3: A merged pair goes out as one request. The address is the doubleword base (bits [2:0] cleared), the byte enables are 0xFF, and lanes 0-3 hold the lower word's data and lanes 4-7 the upper word's.
- R4: The pair merges whether the head entry is the lower word (address bit 2 clear) or the upper word.
- R5: Merging happens only when the second entry is valid in the cycle the head entry is captured. A head entry with no partner is issued at once, and a store arriving later is issued on its own.
- R6: With the gather enable low, or with the little-endian mode input high, every store goes out alone.
- R7: A store whose flag field (bit 0 byte-reversed, bit 1 store-conditional, bit 2 external-control, bit 3 issued during a page table search) has any bit set never merges.
- R8: Two stores merge only if their address bits above bit 2 match and their bit 2 differs. Two stores to the same word half go out separately.
- R9: A store sent alone has byte enables equal to its size mask shifted left by address bits [2:0]. Its right-aligned data moves to the same lanes, and disabled lanes are zero.
- R10: Requests leave in queue order. A merged pair takes the place of the older entry, and `sq_pop_pair` is high in its handshake cycle.
- R11: While `bus_valid` is high and `bus_ready` is low, the address, data and byte enables hold. `sq_pop` is high only in the cycle where `bus_valid` and `bus_ready` are both high.
- R12: During reset, `bus_valid`, `sq_pop` and `sq_pop_pair` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gather_en | input | 1 | Global gathering enable |
| le_mode | input | 1 | Little-endian mode, disables gathering |
| sq0_valid | input | 1 | Head queue entry valid |
| sq0_addr | input | 32 | Head entry byte address |
| sq0_data | input | 64 | Head entry data, right-aligned |
| sq0_size | input | 2 | Head entry size code |
| sq0_attr | input | 3 | Head entry memory attributes |
| sq0_flags | input | 4 | Head entry excluding flags |
| sq1_valid | input | 1 | Second queue entry valid |
| sq1_addr | input | 32 | Second entry byte address |
| sq1_data | input | 64 | Second entry data, right-aligned |
| sq1_size | input | 2 | Second entry size code |
| sq1_attr | input | 3 | Second entry memory attributes |
| sq1_flags | input | 4 | Second entry excluding flags |
| sq_pop | output | 1 | Pop the head entry |
| sq_pop_pair | output | 1 | Also pop the second entry |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts request |
| bus_addr | output | 32 | Doubleword-aligned request address |
| bus_data | output | 64 | Lane-placed write data |
| bus_be | output | 8 | Byte enables |

## Verification
A wrong merge decision shows in the handshake cycle of the affected store. It appears as byte enables of 0xFF where 0x0F or 0xF0 was due, or the reverse, together with a wrong `sq_pop_pair`. Every later request then arrives out of step with the expected order. A corrupted lane placement shows as wrong data or byte enables on that same beat. Losing the held request during a stall shows one cycle later as changed address, data or enables while `bus_valid` is still high. A stuck offer state shows as `bus_valid` never dropping, so the expected requests stay unmatched.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 64;
    localparam int BYTES      = DATA_W / 8;
    localparam int OFF_W      = $clog2(BYTES);
    localparam int WORD_BYTES = 4;
    localparam int WORD_OFF   = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } sg_size_e;

    typedef struct packed {
        logic grd;
        logic ci;
        logic wt;
    } sg_attr_t;

    typedef struct packed {
        logic walk;
        logic extc;
        logic stcx;
        logic brev;
    } sg_kind_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        sg_size_e          size;
        sg_attr_t          attr;
        sg_kind_t          kind;
    } sg_store_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BYTES-1:0]  be;
        logic              pair;
    } sg_req_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } sg_state_e;

    function automatic logic [BYTES-1:0] size_mask(input sg_size_e s);
        logic [BYTES-1:0] m;
        for (int i = 0; i < BYTES; i++) begin
            m[i] = (i < (1 << int'(s)));
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] dw_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/sg_eligible.sv
module sg_eligible
    import sg_pkg::*;
(
    input  logic [WORD_OFF-1:0] addr_lo,
    input  sg_size_e            size,
    input  sg_attr_t            attr,
    input  sg_kind_t            kind,
    output logic                elig
);
    logic mem_ok;
    logic shape_ok;
    logic kind_ok;

    always_comb begin
        mem_ok   = !attr.grd && (attr.wt || attr.ci);
        shape_ok = (size == SZ_WORD) && (addr_lo == '0);
        kind_ok  = !(kind.brev || kind.stcx || kind.extc || kind.walk);
        elig     = mem_ok && shape_ok && kind_ok;
    end
endmodule

// File: rtl/sg_lane_place.sv
module sg_lane_place
    import sg_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  sg_size_e          size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [BYTES-1:0]  be
);
    logic [BYTES-1:0]  smask;
    logic [DATA_W-1:0] masked;

    assign smask = size_mask(size);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign masked[8*b +: 8] = smask[b] ? din[8*b +: 8] : 8'h00;
    end

    always_comb begin
        be   = smask << off;
        dout = masked << {off, 3'b000};
    end
endmodule

// File: rtl/sg_pair_check.sv
module sg_pair_check
    import sg_pkg::*;
(
    input  logic                       gather_en,
    input  logic                       le_mode,
    input  logic                       second_valid,
    input  logic [1:0]                 elig,
    input  logic [ADDR_W-1:WORD_OFF]   addr0_hi,
    input  logic [ADDR_W-1:WORD_OFF]   addr1_hi,
    output logic                       merge
);
    logic same_dw;
    logic diff_half;

    always_comb begin
        same_dw   = addr0_hi[ADDR_W-1:OFF_W] == addr1_hi[ADDR_W-1:OFF_W];
        diff_half = addr0_hi[WORD_OFF] != addr1_hi[WORD_OFF];
        merge     = gather_en && !le_mode && second_valid
                    && elig[0] && elig[1] && same_dw && diff_half;
    end
endmodule

// File: rtl/sg_write_combiner.sv
module sg_write_combiner
    import sg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        gather_en,
    input  logic        le_mode,
    input  logic        sq0_valid,
    input  logic [31:0] sq0_addr,
    input  logic [63:0] sq0_data,
    input  logic [1:0]  sq0_size,
    input  logic [2:0]  sq0_attr,
    input  logic [3:0]  sq0_flags,
    input  logic        sq1_valid,
    input  logic [31:0] sq1_addr,
    input  logic [63:0] sq1_data,
    input  logic [1:0]  sq1_size,
    input  logic [2:0]  sq1_attr,
    input  logic [3:0]  sq1_flags,
    output logic        sq_pop,
    output logic        sq_pop_pair,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic [31:0] bus_addr,
    output logic [63:0] bus_data,
    output logic [7:0]  bus_be
);
    localparam int NENT = 2;

    sg_store_t         ent   [NENT];
    logic [NENT-1:0]   elig;
    logic [DATA_W-1:0] pdata [NENT];
    logic [BYTES-1:0]  pbe   [NENT];
    logic              merge;
    sg_req_t           next_req;
    sg_req_t           req_q;
    sg_state_e         state;

    always_comb begin
        ent[0] = '{addr: sq0_addr, data: sq0_data, size: sg_size_e'(sq0_size),
                   attr: sg_attr_t'(sq0_attr), kind: sg_kind_t'(sq0_flags)};
        ent[1] = '{addr: sq1_addr, data: sq1_data, size: sg_size_e'(sq1_size),
                   attr: sg_attr_t'(sq1_attr), kind: sg_kind_t'(sq1_flags)};
    end

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        sg_eligible u_elig (
            .addr_lo (ent[e].addr[WORD_OFF-1:0]),
            .size    (ent[e].size),
            .attr    (ent[e].attr),
            .kind    (ent[e].kind),
            .elig    (elig[e])
        );
        sg_lane_place u_place (
            .off  (ent[e].addr[OFF_W-1:0]),
            .size (ent[e].size),
            .din  (ent[e].data),
            .dout (pdata[e]),
            .be   (pbe[e])
        );
    end

    sg_pair_check u_pair (
        .gather_en    (gather_en),
        .le_mode      (le_mode),
        .second_valid (sq1_valid),
        .elig         (elig),
        .addr0_hi     (ent[0].addr[ADDR_W-1:WORD_OFF]),
        .addr1_hi     (ent[1].addr[ADDR_W-1:WORD_OFF]),
        .merge        (merge)
    );

    always_comb begin
        next_req.addr = dw_base(ent[0].addr);
        next_req.data = merge ? (pdata[0] | pdata[1]) : pdata[0];
        next_req.be   = merge ? (pbe[0] | pbe[1]) : pbe[0];
        next_req.pair = merge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sq0_valid) begin
                        req_q <= next_req;
                        state <= ST_OFFER;
                    end
                end
                ST_OFFER: begin
                    if (bus_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_valid   = (state == ST_OFFER);
    assign bus_addr    = req_q.addr;
    assign bus_data    = req_q.data;
    assign bus_be      = req_q.be;
    assign sq_pop      = bus_valid && bus_ready;
    assign sq_pop_pair = sq_pop && req_q.pair;

    // R11: offered request holds until accepted
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                    && $stable(bus_data) && $stable(bus_be));

    // R10: a merged pair always retires both entries in one handshake
    p_pair_pops_both_r10: assert property (@(posedge clk) disable iff (rst)
        sq_pop_pair |-> sq_pop && bus_valid);

    // R3: a merged request covers the whole doubleword
    p_pair_full_be_r3: assert property (@(posedge clk) disable iff (rst)
        bus_valid && req_q.pair |-> bus_be == {BYTES{1'b1}});

    // R6, R5: a merge needs gathering on, big-endian, and a pending partner
    p_pair_needs_mode_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) && req_q.pair |-> $past(gather_en && !le_mode && sq1_valid));
endmodule

// File: tb/tb_sg_write_combiner.sv
module tb_sg_write_combiner;
    import sg_pkg::*;

    typedef struct {
        logic [31:0] addr;
        logic [63:0] data;
        logic [7:0]  be;
        logic        pair;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gather_en = 1'b1;
    logic        le_mode = 1'b0;
    logic        sq0_valid = 1'b0, sq1_valid = 1'b0;
    logic [31:0] sq0_addr = '0, sq1_addr = '0;
    logic [63:0] sq0_data = '0, sq1_data = '0;
    logic [1:0]  sq0_size = '0, sq1_size = '0;
    logic [2:0]  sq0_attr = '0, sq1_attr = '0;
    logic [3:0]  sq0_flags = '0, sq1_flags = '0;
    logic        sq_pop, sq_pop_pair, bus_valid;
    logic        bus_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [63:0] bus_data;
    logic [7:0]  bus_be;

    int n_cmp = 0;
    int n_bad = 0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    sg_store_t sqm [$];
    exp_t      expq [$];

    always #2 clk = ~clk;

    sg_write_combiner dut (
        .clk(clk), .rst(rst), .gather_en(gather_en), .le_mode(le_mode),
        .sq0_valid(sq0_valid), .sq0_addr(sq0_addr), .sq0_data(sq0_data),
        .sq0_size(sq0_size), .sq0_attr(sq0_attr), .sq0_flags(sq0_flags),
        .sq1_valid(sq1_valid), .sq1_addr(sq1_addr), .sq1_data(sq1_data),
        .sq1_size(sq1_size), .sq1_attr(sq1_attr), .sq1_flags(sq1_flags),
        .sq_pop(sq_pop), .sq_pop_pair(sq_pop_pair), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [63:0] d, input logic [1:0] sz,
                        input logic [2:0] at, input logic [3:0] fl);
        sg_store_t s;
        s.addr = a; s.data = d; s.size = sg_size_e'(sz);
        s.attr = sg_attr_t'(at); s.kind = sg_kind_t'(fl);
        sqm.push_back(s);
    endtask

    task automatic expect_req(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                              input logic pr, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.be = be; e.pair = pr; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while ((sqm.size() != 0 || expq.size() != 0) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) chk(1'b0, {tag, " drain"}, 64'(sqm.size()), 64'd0);
        @(negedge clk);
    endtask

    // monitor: compares handshakes, then updates queue model and inputs after the edge
    initial begin
        bit          fire;
        bit          hold_prev = 1'b0;
        logic [31:0] h_addr;
        logic [63:0] h_data;
        logic [7:0]  h_be;
        bit          pair_fire;
        forever begin
            @(negedge clk);
            fire = 1'b0;
            pair_fire = 1'b0;
            if (!rst) begin
                if (hold_prev)
                    chk(bus_valid && bus_addr == h_addr && bus_data == h_data && bus_be == h_be,
                        "R11 hold", {bus_addr, 24'd0, bus_be}, {h_addr, 24'd0, h_be});
                hold_prev = bus_valid && !bus_ready;
                h_addr = bus_addr; h_data = bus_data; h_be = bus_be;
                fire = bus_valid && bus_ready;
                if (!fire && sq_pop)
                    chk(1'b0, "R11 pop without handshake", 64'(sq_pop), 64'd0);
                if (fire) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R10 unexpected request", {32'd0, bus_addr}, 64'd0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(bus_addr == e.addr, {e.tag, " addr"}, {32'd0, bus_addr}, {32'd0, e.addr});
                        chk(bus_data == e.data, {e.tag, " data"}, bus_data, e.data);
                        chk(bus_be == e.be, {e.tag, " be"}, {56'd0, bus_be}, {56'd0, e.be});
                        chk(sq_pop && sq_pop_pair == e.pair, {e.tag, " R10 pop"},
                            {62'd0, sq_pop, sq_pop_pair}, {62'd0, 1'b1, e.pair});
                    end
                    pair_fire = sq_pop_pair;
                end
            end
            @(posedge clk);
            #1;
            if (fire) begin
                if (sqm.size() != 0) void'(sqm.pop_front());
                if (pair_fire && sqm.size() != 0) void'(sqm.pop_front());
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_ready = stall_mode ? lfsr[0] : 1'b1;
            sq0_valid = sqm.size() > 0;
            sq1_valid = sqm.size() > 1;
            if (sqm.size() > 0) begin
                sq0_addr = sqm[0].addr; sq0_data = sqm[0].data; sq0_size = sqm[0].size;
                sq0_attr = sqm[0].attr; sq0_flags = sqm[0].kind;
            end
            if (sqm.size() > 1) begin
                sq1_addr = sqm[1].addr; sq1_data = sqm[1].data; sq1_size = sqm[1].size;
                sq1_attr = sqm[1].attr; sq1_flags = sqm[1].kind;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    localparam logic [2:0] A_WT = 3'b001, A_CI = 3'b010, A_GRD_CI = 3'b110, A_CB = 3'b000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_valid && !sq_pop && !sq_pop_pair, "R12 reset",
            {61'd0, bus_valid, sq_pop, sq_pop_pair}, 64'd0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);

        // R3: lower then upper, write-through
        push(32'h100, 64'h11223344, 2'd2, A_WT, 4'h0);
        push(32'h104, 64'h55667788, 2'd2, A_WT, 4'h0);
        expect_req(32'h100, 64'h55667788_11223344, 8'hFF, 1'b1, "R3 merge");
        drain("R3");

        // R4: upper first, cache-inhibited
        push(32'h10C, 64'hAAAA0001, 2'd2, A_CI, 4'h0);
        push(32'h108, 64'hBBBB0002, 2'd2, A_CI, 4'h0);
        expect_req(32'h108, 64'hAAAA0001_BBBB0002, 8'hFF, 1'b1, "R4 reverse order");
        drain("R4");

        // R6: gathering disabled
        gather_en = 1'b0;
        push(32'h110, 64'h11223344, 2'd2, A_WT, 4'h0);
        push(32'h114, 64'h55667788, 2'd2, A_WT, 4'h0);
        expect_req(32'h110, 64'h00000000_11223344, 8'h0F, 1'b0, "R6 disabled lo");
        expect_req(32'h110, 64'h55667788_00000000, 8'hF0, 1'b0, "R6 disabled hi");
        drain("R6a");
        gather_en = 1'b1;

        // R6: little-endian mode
        le_mode = 1'b1;
        push(32'h118, 64'h01010101, 2'd2, A_WT, 4'h0);
        push(32'h11C, 64'h02020202, 2'd2, A_WT, 4'h0);
        expect_req(32'h118, 64'h00000000_01010101, 8'h0F, 1'b0, "R6 little-endian lo");
        expect_req(32'h118, 64'h02020202_00000000, 8'hF0, 1'b0, "R6 little-endian hi");
        drain("R6b");
        le_mode = 1'b0;

        // R1: guarded and copy-back memory
        push(32'h120, 64'h0A0A0A0A, 2'd2, A_GRD_CI, 4'h0);
        push(32'h124, 64'h0B0B0B0B, 2'd2, A_GRD_CI, 4'h0);
        push(32'h128, 64'h0C0C0C0C, 2'd2, A_CB, 4'h0);
        push(32'h12C, 64'h0D0D0D0D, 2'd2, A_CB, 4'h0);
        expect_req(32'h120, 64'h00000000_0A0A0A0A, 8'h0F, 1'b0, "R1 guarded lo");
        expect_req(32'h120, 64'h0B0B0B0B_00000000, 8'hF0, 1'b0, "R1 guarded hi");
        expect_req(32'h128, 64'h00000000_0C0C0C0C, 8'h0F, 1'b0, "R1 copyback lo");
        expect_req(32'h128, 64'h0D0D0D0D_00000000, 8'hF0, 1'b0, "R1 copyback hi");
        drain("R1");

        // R7: each excluding flag
        for (int k = 0; k < 4; k++) begin
            logic [31:0] b;
            b = 32'h140 + 32'(8 * k);
            push(b,     64'h0000_0000_CAFE_0000 | 64'(k), 2'd2, A_WT, (k == 3) ? 4'h8 : 4'h0);
            push(b + 4, 64'h0000_0000_BEEF_0000 | 64'(k), 2'd2, A_WT, (k == 3) ? 4'h0 : 4'(1 << k));
            expect_req(b, {32'd0, 32'hCAFE_0000 | 32'(k)}, 8'h0F, 1'b0, "R7 flagged lo");
            expect_req(b, {32'hBEEF_0000 | 32'(k), 32'd0}, 8'hF0, 1'b0, "R7 flagged hi");
            drain("R7");
        end

        // R8: different doublewords, then same word half twice (order kept, R10)
        push(32'h200, 64'h11111111, 2'd2, A_WT, 4'h0);
        push(32'h20C, 64'h22222222, 2'd2, A_WT, 4'h0);
        push(32'h210, 64'h33333333, 2'd2, A_WT, 4'h0);
        push(32'h210, 64'h44444444, 2'd2, A_WT, 4'h0);
        expect_req(32'h200, 64'h00000000_11111111, 8'h0F, 1'b0, "R8 other dword a");
        expect_req(32'h208, 64'h22222222_00000000, 8'hF0, 1'b0, "R8 other dword b");
        expect_req(32'h210, 64'h00000000_33333333, 8'h0F, 1'b0, "R8 same half first");
        expect_req(32'h210, 64'h00000000_44444444, 8'h0F, 1'b0, "R8 same half second");
        drain("R8");

        // R2: misaligned word, and halfword beside a word
        push(32'h302, 64'hCAFEF00D, 2'd2, A_WT, 4'h0);
        push(32'h304, 64'h12345678, 2'd2, A_WT, 4'h0);
        push(32'h308, 64'h0000BEEF, 2'd1, A_WT, 4'h0);
        push(32'h30C, 64'h9ABCDEF0, 2'd2, A_WT, 4'h0);
        expect_req(32'h300, 64'h0000CAFE_F00D0000, 8'h3C, 1'b0, "R2 misaligned");
        expect_req(32'h300, 64'h12345678_00000000, 8'hF0, 1'b0, "R2 partner of misaligned");
        expect_req(32'h308, 64'h00000000_0000BEEF, 8'h03, 1'b0, "R2 halfword");
        expect_req(32'h308, 64'h9ABCDEF0_00000000, 8'hF0, 1'b0, "R2 partner of halfword");
        drain("R2");

        // R9: lane placement with junk above the size
        push(32'h403, 64'hFFFFFFFF_FFFFFFAB, 2'd0, A_CB, 4'h0);
        push(32'h416, 64'hFFFFFFFF_FFFFBEEF, 2'd1, A_CB, 4'h0);
        push(32'h428, 64'h01234567_89ABCDEF, 2'd3, A_WT, 4'h0);
        expect_req(32'h400, 64'h00000000_AB000000, 8'h08, 1'b0, "R9 byte");
        expect_req(32'h410, 64'hBEEF0000_00000000, 8'hC0, 1'b0, "R9 half");
        expect_req(32'h428, 64'h01234567_89ABCDEF, 8'hFF, 1'b0, "R9 doubleword alone");
        drain("R9");

        // R10: pairs keep queue order, leftover goes alone
        push(32'h500, 64'hA0A0A0A0, 2'd2, A_WT, 4'h0);
        push(32'h504, 64'hB0B0B0B0, 2'd2, A_WT, 4'h0);
        push(32'h50C, 64'hC0C0C0C0, 2'd2, A_WT, 4'h0);
        push(32'h508, 64'hD0D0D0D0, 2'd2, A_WT, 4'h0);
        push(32'h510, 64'hE0E0E0E0, 2'd2, A_WT, 4'h0);
        expect_req(32'h500, 64'hB0B0B0B0_A0A0A0A0, 8'hFF, 1'b1, "R10 first pair");
        expect_req(32'h508, 64'hC0C0C0C0_D0D0D0D0, 8'hFF, 1'b1, "R10 second pair");
        expect_req(32'h510, 64'h00000000_E0E0E0E0, 8'h0F, 1'b0, "R10 leftover");
        drain("R10");

        // R5: partner arrives after the head was captured
        push(32'h600, 64'h66666666, 2'd2, A_WT, 4'h0);
        expect_req(32'h600, 64'h00000000_66666666, 8'h0F, 1'b0, "R5 lone head");
        expect_req(32'h600, 64'h77777777_00000000, 8'hF0, 1'b0, "R5 late partner");
        @(posedge clk); @(posedge clk); #2;
        push(32'h604, 64'h77777777, 2'd2, A_WT, 4'h0);
        drain("R5");

        // R11: random bus stalls over merged and single traffic
        stall_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [31:0] b;
            b = 32'h700 + 32'(16 * k);
            push(b + 4, 64'h0000_0000_5500_0000 | 64'(k), 2'd2, A_CI, 4'h0);
            push(b,     64'h0000_0000_6600_0000 | 64'(k), 2'd2, A_CI, 4'h0);
            push(b + 8, 64'h0000_0000_7700_0000 | 64'(k), 2'd2, A_GRD_CI, 4'h0);
            expect_req(b, {32'h5500_0000 | 32'(k), 32'h6600_0000 | 32'(k)}, 8'hFF, 1'b1, "R11 stalled pair");
            expect_req(b + 8, {32'd0, 32'h7700_0000 | 32'(k)}, 8'h0F, 1'b0, "R11 stalled single");
        end
        drain("R11");
        stall_mode = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule